// File: doc/BRIEF.md
# Modulo-11 Multi-Mode Step Counter

This block is a synchronous counter whose value always lies in the range 0 to 10 and advances through that range modulo 11. On every rising clock edge two control inputs choose one of four actions: hold the value, add one, add two, or subtract one. Each result wraps inside the range, so stepping up past 10 continues from 0 and stepping down from 0 continues at 10.

The state is a plain four-bit register, the same storage a free-running modulo-16 counter would use. Combinational logic folds each candidate result back into the eleven legal codes. A synchronous active-high reset clears the count. Any stray code from 11 to 15 found in the register is flushed to 0 on the next edge. The output is the register itself, with no logic after it.

Top module: `mod11_stepper`

## Requirements
- R1: Starting from reset and under any sequence of modes, `count` only takes values from 0 to 10.
- R2: With `{step_a, step_b}` = 2'b00, the count keeps its current value across the clock edge.
- R3: With `{step_a, step_b}` = 2'b01, the next count is (count + 1) mod 11, so 10 steps to 0.
- R4: With `{step_a, step_b}` = 2'b10, the next count is (count + 2) mod 11, so 9 steps to 0 and 10 steps to 1.
- R5: With `{step_a, step_b}` = 2'b11, the next count is (count - 1) mod 11, so 0 steps to 10.
- R6: A high `rst` sampled on a rising edge sets the count to 0, whatever the mode inputs are.
- R7: If the register holds a code from 11 to 15, the next rising edge sets it to 0 in every mode.
- R8: The count changes only at a rising clock edge. A change of the mode inputs between edges leaves `count` as it is until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_a | input | 1 | Mode select, upper bit |
| step_b | input | 1 | Mode select, lower bit |
| count | output | 4 | Current count, 0 to 10 |

## Verification
The bench starts from every legal value and applies every mode, so it hits the wrap points: 10 plus one, 9 and 10 plus two, and 0 minus one. A counter that wraps at 16 would show 11, 12 or 15 at these points. A wrong fold for the +2 step would give 0 or 2 from 10 instead of 1. The bench injects each illegal code 11 to 15 into the register under every mode; a design without the flush would go on counting outside the range. It also asserts reset against every mode, checks that the output does not move between edges, and runs a long pseudo-random walk of modes against an arithmetic model.

// File: rtl/mod11_stepper.sv
module mod11_stepper (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_a,
  input  logic       step_b,
  output logic [3:0] count
);

  localparam logic [3:0] TOP = 4'd10;

  logic [3:0] cnt_q;
  logic [3:0] inc1, inc2, dec1, nxt;
  logic       legal;

  assign legal = (cnt_q <= TOP);
  assign inc1  = (cnt_q == TOP) ? 4'd0 : cnt_q + 4'd1;
  assign inc2  = (cnt_q >= TOP - 4'd1) ? cnt_q - (TOP - 4'd1) : cnt_q + 4'd2;
  assign dec1  = (cnt_q == 4'd0) ? TOP : cnt_q - 4'd1;

  always_comb begin
    case ({step_a, step_b})
      2'b00:   nxt = cnt_q;
      2'b01:   nxt = inc1;
      2'b10:   nxt = inc2;
      default: nxt = dec1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !legal) cnt_q <= 4'd0;
    else               cnt_q <= nxt;
  end

  assign count = cnt_q;

endmodule

// File: rtl/mod11_stepper_chk.sv
module mod11_stepper_chk (
  input logic       clk,
  input logic       rst,
  input logic       step_a,
  input logic       step_b,
  input logic [3:0] count
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (count == 4'd0)); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !step_a && !step_b && count <= 4'd10) |=> $stable(count)); // R2

  AST_UP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !step_a && step_b && count <= 4'd10) |=>
    (count == (($past(count) == 4'd10) ? 4'd0 : $past(count) + 4'd1))); // R3

  AST_UP_TWO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && step_a && !step_b && count <= 4'd10) |=>
    (count == (($past(count) > 4'd8) ? $past(count) - 4'd9 : $past(count) + 4'd2))); // R4

  AST_DOWN_ONE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && step_a && step_b && count <= 4'd10) |=>
    (count == (($past(count) == 4'd0) ? 4'd10 : $past(count) - 4'd1))); // R5

  AST_ILLEGAL_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (count > 4'd10) |=> (count == 4'd0)); // R7

  AST_LEGAL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && count <= 4'd10) |=> (count <= 4'd10)); // R1

endmodule

bind mod11_stepper mod11_stepper_chk u_chk (
  .clk(clk), .rst(rst), .step_a(step_a), .step_b(step_b), .count(count)
);

// File: tb/sim_mod11_stepper.sv
module sim_mod11_stepper;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_a = 1'b0;
  logic       step_b = 1'b0;
  logic [3:0] count;
  logic [3:0] inj;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mod11_stepper u0 (.clk(clk), .rst(rst), .step_a(step_a), .step_b(step_b), .count(count));

  function automatic int model(int s, int m);
    case (m)
      0:       return s;
      1:       return (s + 1) % 11;
      2:       return (s + 2) % 11;
      default: return (s + 10) % 11;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(int m);
    step_a = m[1];
    step_b = m[0];
  endtask

  task automatic edge_step();
    @(negedge clk);
  endtask

  task automatic go_to(int s);
    rst = 1'b1;
    set_mode(3);
    edge_step();
    rst = 1'b0;
    set_mode(1);
    for (int i = 0; i < s; i++) edge_step();
  endtask

  initial begin
    @(negedge clk);
    edge_step();
    check("R6 reset value", count, 0);

    for (int s = 0; s < 11; s++) begin
      for (int m = 0; m < 4; m++) begin
        go_to(s);
        check("R1 setup", count, s);
        set_mode(m);
        #2;
        check("R8 no change between edges", count, s);
        edge_step();
        case (m)
          0: check("R2 hold", count, model(s, m));
          1: check("R3 plus one", count, model(s, m));
          2: check("R4 plus two", count, model(s, m));
          default: check("R5 minus one", count, model(s, m));
        endcase
      end
    end

    for (int m = 0; m < 4; m++) begin
      go_to(7);
      set_mode(m);
      rst = 1'b1;
      edge_step();
      rst = 1'b0;
      check("R6 reset over mode", count, 0);
    end

    for (int v = 11; v < 16; v++) begin
      for (int m = 0; m < 4; m++) begin
        rst = 1'b1;
        edge_step();
        rst = 1'b0;
        set_mode(0);
        edge_step();
        inj = 4'(v);
        force u0.cnt_q = inj;
        #1;
        release u0.cnt_q;
        set_mode(m);
        check("R7 injected", count, v);
        edge_step();
        check("R7 illegal flush", count, 0);
      end
    end

    begin
      int exp;
      logic [7:0] lfsr;
      exp  = 0;
      lfsr = 8'hA5;
      rst = 1'b1;
      edge_step();
      rst = 1'b0;
      for (int i = 0; i < 600; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        set_mode(int'(lfsr[1:0]));
        edge_step();
        exp = model(exp, int'(lfsr[1:0]));
        if (count > 4'd10) check("R1 range", count, exp);
        else check("R3 R4 R5 R2 walk", count, exp);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: count=%0d expected=finished run", count);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule